// File: doc/BRIEF.md
# Staggered Four-Channel Pulse-Width DAC

This block drives four open-drain pins with 8-bit pulse-width modulated waveforms. An RC filter outside the block turns each waveform into an analog level. All logic runs on the pixel clock. A prescaler produces a one-cycle enable, the PWM tick, every 1, 2, 4 or 8 input clocks. A shared 8-bit slot counter advances on each tick, so one PWM period lasts 256 ticks.

Each channel starts its period at its own slot value. The channels therefore switch on in order, one tick apart, instead of all at once, which spreads the switching current across the period. The outputs are pull-down enables. A 1 pulls the pin low and a 0 releases it so the external resistor takes it high. The logic never drives a pin high.

A write strobe captures four duty values into holding registers. Each channel copies its held value into its working duty only at the start of its own next period, so a write can never shorten or split a pulse already in progress. Each channel is a two-state machine. `CH_LOW` holds the pin low. `CH_HIGH` releases it. The rise transition goes from `CH_LOW` to `CH_HIGH` when the channel's period starts with a non-zero duty. The fall transition goes from `CH_HIGH` to `CH_LOW` once the channel's phase reaches its duty. Every other tick keeps the current state.

Top module: `pwm_stag_dac`

## Requirements
- R1: `div_sel` codes 0, 1, 2 and 3 make the PWM tick occur every 8, 4, 2 and 1 input clocks. The slot counter advances by one per tick, so the distance between two successive rises of one channel is 256 × divide input clocks.
- R2: For a duty value D from 1 to 255, each period keeps the channel released (`pd_en` bit 0) for exactly D × divide input clocks.
- R3: A duty of 0 keeps the channel's `pd_en` bit at 1 for the whole period, with no released time at all.
- R4: Channel n is released when the slot counter takes the value n. With non-zero duties, the rise of channel n+1 follows the rise of channel n by exactly one tick (divide input clocks), in the order 0, 1, 2, 3.
- R5: A written duty value takes effect only at the start of that channel's next period. A pulse that is already in progress keeps the width set by the old duty.
- R6: While `rst_n` is low, every `pd_en` bit is 1, the slot counter is 0, and all held and working duties are 0. After reset, no channel is released until a non-zero duty is written.
- R7: `pd_en` bit n = 1 means pin n is pulled low, and 0 means it is released. The outputs change only on the clock edge that follows a tick.
- R8: A clock edge with `duty_wr` high loads all four duties from `duty_in`, with channel n in bits [8n+7:8n]. Changes on `duty_in` while `duty_wr` is low have no effect.
- R9: A duty of 255 holds the channel low for exactly one tick per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; all registers use its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Prescale select: 0 → /8, 1 → /4, 2 → /2, 3 → /1 |
| duty_wr | input | 1 | Load strobe for the four held duty values |
| duty_in | input | 32 | Four duty values, channel n in bits [8n+7:8n] |
| pd_en | output | 4 | Pull-down enables, bit n for pin n (1 = pull low) |

## Verification
A write is captured at the first rising edge that sees `duty_wr`. It reaches a pin only on the tick that brings the slot counter to that channel's index. From then on, every rise and fall sits one edge after a tick. All results are therefore distances between edges: pulse widths, periods, the gap between channel rises, and the low gap of a full-scale duty. These equal duty × divide, 256 × divide, divide, and divide input clocks respectively. A monitor timestamps every output edge at the falling clock edge. The checks compare differences of those timestamps, so the fixed register latency cancels out. After each change of divide or duty, the first pulse is discarded so that only settled periods are measured.

// File: rtl/pwm_stag_pkg.sv
package pwm_stag_pkg;

    localparam int unsigned NUM_CH = 4;
    localparam int unsigned DUTY_W = 8;
    localparam int unsigned SEL_W  = 2;

    // Per-channel output state: pin held low or released
    typedef enum logic [0:0] {
        CH_LOW  = 1'b0,
        CH_HIGH = 1'b1
    } ch_state_e;

endpackage

// File: rtl/pwm_stag_prescale.sv
module pwm_stag_prescale #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    // Largest divide is 2**DIV_W, reached with sel = 0
    localparam int unsigned DIV_W = (1 << SEL_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Each step of sel halves the divide ratio
    always_comb begin
        mask = {DIV_W{1'b1}} >> sel;
        tick = ((div_q & mask) == mask);
    end

endmodule

// File: rtl/pwm_stag_counter.sv
module pwm_stag_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/pwm_stag_channel.sv
module pwm_stag_channel
    import pwm_stag_pkg::*;
#(
    parameter int unsigned DUTY_W_P = 8,
    parameter int unsigned CH_IDX   = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [DUTY_W_P-1:0] cnt,
    input  logic                wr,
    input  logic [DUTY_W_P-1:0] duty_new,
    output logic [DUTY_W_P-1:0] duty_act,
    output logic                pd
);

    localparam logic [DUTY_W_P-1:0] SLOT = DUTY_W_P'(CH_IDX);

    ch_state_e           state_q, state_d;
    logic [DUTY_W_P-1:0] hold_q;
    logic [DUTY_W_P-1:0] act_q, act_d;
    logic [DUTY_W_P-1:0] cnt_nxt;
    logic [DUTY_W_P-1:0] phase_nxt;
    logic                start;
    logic                in_pulse;

    // Holding register: loaded by the write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (wr) begin
            hold_q <= duty_new;
        end
    end

    // Working duty changes only when this channel's period begins
    always_comb begin
        cnt_nxt   = cnt + 1'b1;
        start     = tick && (cnt_nxt == SLOT);
        act_d     = start ? hold_q : act_q;
        phase_nxt = cnt_nxt - SLOT;
        in_pulse  = (phase_nxt < act_d);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else begin
            act_q <= act_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                CH_LOW:  if (in_pulse)  state_d = CH_HIGH; // rise
                CH_HIGH: if (!in_pulse) state_d = CH_LOW;  // fall
                default: state_d = CH_LOW;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        pd       = (state_q != CH_HIGH);
        duty_act = act_q;
    end

endmodule

// File: rtl/pwm_stag_dac.sv
module pwm_stag_dac
    import pwm_stag_pkg::*;
#(
    parameter int unsigned CH_N  = NUM_CH,
    parameter int unsigned DW    = DUTY_W,
    parameter int unsigned SW    = SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SW-1:0]    div_sel,
    input  logic             duty_wr,
    input  logic [CH_N*DW-1:0] duty_in,
    output logic [CH_N-1:0]  pd_en
);

    logic              tick_w;
    logic [DW-1:0]     cnt_w;
    logic [CH_N*DW-1:0] act_w;

    pwm_stag_prescale #(.SEL_W(SW)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (div_sel),
        .tick  (tick_w)
    );

    pwm_stag_counter #(.CNT_W(DW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_w),
        .cnt   (cnt_w)
    );

    for (genvar g = 0; g < CH_N; g++) begin : g_ch
        pwm_stag_channel #(.DUTY_W_P(DW), .CH_IDX(g)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_w),
            .cnt      (cnt_w),
            .wr       (duty_wr),
            .duty_new (duty_in[g*DW +: DW]),
            .duty_act (act_w[g*DW +: DW]),
            .pd       (pd_en[g])
        );
    end

endmodule

// File: rtl/pwm_stag_dac_chk.sv
module pwm_stag_dac_chk #(
    parameter int unsigned CH_N = 4,
    parameter int unsigned DW   = 8,
    parameter int unsigned SW   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic [DW-1:0]      cnt,
    input logic [SW-1:0]      div_sel,
    input logic [CH_N*DW-1:0] act,
    input logic [CH_N-1:0]    pd_en
);

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(cnt) + 1'b1)); // R1

    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R1

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == {SW{1'b1}}) |-> tick); // R1

    AST_OUT_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pd_en)); // R7

    for (genvar g = 0; g < CH_N; g++) begin : g_chk
        localparam logic [DW-1:0] SLOT = DW'(g);
        localparam logic [DW-1:0] PREV = DW'(g) - 1'b1;

        AST_RISE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pd_en[g]) |-> (cnt == SLOT)); // R4

        AST_DUTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(tick && (cnt == PREV)) |=> $stable(act[g*DW +: DW])); // R5

        AST_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            (act[g*DW +: DW] == '0) |-> pd_en[g]); // R3
    end

endmodule

bind pwm_stag_dac pwm_stag_dac_chk #(.CH_N(CH_N), .DW(DW), .SW(SW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_w),
    .cnt     (cnt_w),
    .div_sel (div_sel),
    .act     (act_w),
    .pd_en   (pd_en)
);

// File: tb/sim_pwm_stag_dac.sv
`timescale 1ns/1ps
module sim_pwm_stag_dac;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  div_sel = 2'd0;
    logic        duty_wr = 1'b0;
    logic [31:0] duty_in = '0;
    logic [3:0]  pd_en;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int rise_cyc [4];
    int fall_cyc [4];
    int rise_n   [4];
    int fall_n   [4];
    logic [3:0] prev_pd = 4'hF;

    always #2.5 clk = ~clk;

    pwm_stag_dac u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .duty_wr (duty_wr),
        .duty_in (duty_in),
        .pd_en   (pd_en)
    );

    // Edge monitor, sampled away from the active edge
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            for (int c = 0; c < 4; c++) begin
                if (prev_pd[c] && !pd_en[c]) begin
                    rise_cyc[c] <= cyc;
                    rise_n[c]   <= rise_n[c] + 1;
                end
                if (!prev_pd[c] && pd_en[c]) begin
                    fall_cyc[c] <= cyc;
                    fall_n[c]   <= fall_n[c] + 1;
                end
            end
        end
        prev_pd <= pd_en;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic write_duty(input logic [7:0] d0, d1, d2, d3);
        duty_in = {d3, d2, d1, d0};
        duty_wr = 1'b1;
        step(1);
        duty_wr = 1'b0;
    endtask

    task automatic wait_rise(input int ch, output int t);
        int r0 = rise_n[ch];
        while (rise_n[ch] == r0) step(1);
        t = rise_cyc[ch];
    endtask

    // Width of the next complete released pulse on ch
    task automatic next_width(input int ch, output int w);
        int t, f0;
        wait_rise(ch, t);
        f0 = fall_n[ch];
        while (fall_n[ch] == f0) step(1);
        w = fall_cyc[ch] - t;
    endtask

    task automatic t_reset();
        int rel = 0;
        chk(pd_en == 4'hF, "R6 reset pull-down", pd_en, 15);
        rst_n = 1'b1;
        for (int i = 0; i < 2200; i++) begin
            step(1);
            if (pd_en != 4'hF) rel++;
        end
        chk(rel == 0, "R6 no release before write", rel, 0);
    endtask

    task automatic t_fields();
        int w;
        div_sel = 2'd3;
        write_duty(8'd10, 8'd20, 8'd30, 8'd40);
        next_width(0, w);
        for (int c = 0; c < 4; c++) begin
            next_width(c, w);
            chk(w == 10 * (c + 1), "R8 field position width", w, 10 * (c + 1));
        end
    endtask

    task automatic t_ignored();
        int w;
        duty_in = {8'd200, 8'd200, 8'd200, 8'd200};
        next_width(0, w);
        next_width(0, w);
        chk(w == 10, "R8 input ignored without strobe", w, 10);
    endtask

    task automatic t_prescale(input logic [1:0] sel, input int div, input logic [7:0] d);
        int w, t1, t2;
        div_sel = sel;
        write_duty(d, d, d, d);
        next_width(0, w);
        next_width(0, w);
        chk(w == d * div, "R2 high time", w, d * div);
        wait_rise(0, t1);
        wait_rise(0, t2);
        chk(t2 - t1 == 256 * div, "R1 period", t2 - t1, 256 * div);
    endtask

    task automatic t_stagger(input logic [1:0] sel, input int div);
        int t0, t1;
        div_sel = sel;
        write_duty(8'd60, 8'd60, 8'd60, 8'd60);
        wait_rise(3, t0);
        for (int c = 0; c < 3; c++) begin
            wait_rise(c, t0);
            wait_rise(c + 1, t1);
            chk(t1 - t0 == div, "R4 stagger", t1 - t0, div);
        end
    endtask

    task automatic t_full();
        int w, t;
        div_sel = 2'd2;
        write_duty(8'd255, 8'd255, 8'd255, 8'd255);
        next_width(1, w);
        next_width(1, w);
        chk(w == 510, "R9 full-scale high time", w, 510);
        wait_rise(1, t);
        chk(t - fall_cyc[1] == 2, "R9 one-tick low gap", t - fall_cyc[1], 2);
    endtask

    task automatic t_buffer();
        int w, t, f0;
        div_sel = 2'd3;
        write_duty(8'd100, 8'd100, 8'd100, 8'd100);
        next_width(0, w);
        wait_rise(0, t);
        f0 = fall_n[0];
        step(10);
        write_duty(8'd30, 8'd30, 8'd30, 8'd30);
        while (fall_n[0] == f0) step(1);
        w = fall_cyc[0] - t;
        chk(w == 100, "R5 current pulse keeps old duty", w, 100);
        next_width(0, w);
        chk(w == 30, "R5 next period uses new duty", w, 30);
    endtask

    task automatic t_zero();
        int rel = 0;
        div_sel = 2'd3;
        write_duty(8'd0, 8'd0, 8'd0, 8'd0);
        step(600);
        for (int i = 0; i < 300; i++) begin
            step(1);
            if (pd_en != 4'hF) rel++;
        end
        chk(rel == 0, "R3 zero duty stays low", rel, 0);
        chk(pd_en == 4'hF, "R7 pull-down encoding", pd_en, 15);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 4; c++) begin
            rise_n[c] = 0;
            fall_n[c] = 0;
            rise_cyc[c] = 0;
            fall_cyc[c] = 0;
        end
        step(4);
        t_reset();
        t_fields();
        t_ignored();
        t_prescale(2'd3, 1, 8'd1);
        t_prescale(2'd2, 2, 8'd77);
        t_prescale(2'd1, 4, 8'd50);
        t_prescale(2'd0, 8, 8'd128);
        t_stagger(2'd0, 8);
        t_stagger(2'd3, 1);
        t_full();
        t_buffer();
        t_zero();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule